// File: doc/BRIEF.md
# Deduplicating Error Message Cache

After a configuration memory CRC error, an upstream unloader sends error message words to this block, one word per valid strobe. The block compares each word with every occupied cache line. A word that is already stored is dropped. A new word goes into the next free line. When every line is occupied, a further new word is discarded and a sticky overflow flag is raised for the host.

The host sees the entries one at a time, oldest first. An interrupt line is high while entries remain that the host has not acknowledged. The host reads the current entry, performs its own sensitivity lookup, and pulses acknowledge. The block then moves to the next entry. The interrupt drops for one cycle after each accepted acknowledge, so every entry produces its own rising edge. The cache contents are cleared only by reset.

Top module: `errcache_top`

## Requirements
- R1: Reset is asynchronous and active low (`rst_ni`). While it is asserted and after it is released, `irq_o`, `ovf_o`, `pending_o` and `entry_o` are all zero, and the cache is empty.
- R2: A valid word that matches no occupied line is written into the next free line at the clock edge where it is sampled, and `pending_o` increases by one in the following cycle.
- R3: A valid word equal to any occupied line is dropped, even if the host has already acknowledged that line, and it leaves `pending_o` and the stored contents unchanged.
- R4: When all `DEPTH` lines are occupied, a valid new word is discarded and sets `ovf_o` in the following cycle. A discarded word is never presented on `entry_o`.
- R5: `ovf_o` stays set until a cycle in which `ovf_clr_i` is high. If a new overflow occurs in the same cycle as the clear, the set takes priority.
- R6: `irq_o` is high exactly when `pending_o` is nonzero, except in the cycle that follows an accepted acknowledge, when it is low.
- R7: `entry_o` shows the oldest unacknowledged entry, in the order the entries were written. It shows zero when `pending_o` is zero.
- R8: An `ack_i` pulse while `pending_o` is nonzero advances to the next entry and lowers `pending_o` by one in the following cycle. An `ack_i` pulse while `pending_o` is zero is ignored.
- R9: A write and an accepted acknowledge in the same cycle leave `pending_o` unchanged and advance `entry_o` to the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Strobe that qualifies `msg_data_i` |
| msg_data_i | input | WIDTH | Error message word |
| ack_i | input | 1 | Host acknowledge of the current entry |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| irq_o | output | 1 | Interrupt to the host |
| entry_o | output | WIDTH | Oldest unacknowledged entry |
| pending_o | output | $clog2(DEPTH+1) | Number of unacknowledged entries |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench repeats words that the host has already acknowledged. A design that compared only the pending lines would store such a word again and raise a second interrupt for it. The bench fills the cache and then sends one more new word. A design that wrapped around would overwrite the oldest line, and one that ignored the full state would lose the overflow flag. The bench also drives an overflow and a clear in the same cycle, acknowledges with nothing pending, and writes while acknowledging. These cases expose a clear that wins over a set, a count that underflows, and a count that drifts by one. Finally, the bench checks that the interrupt is low in the cycle right after each acknowledge, which catches a design that holds the interrupt level across entries.

// File: rtl/errcache_pkg.sv
package errcache_pkg;
  localparam int unsigned DEF_WIDTH = 64;
  localparam int unsigned DEF_DEPTH = 8;

  function automatic int unsigned cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int unsigned idx_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/errcache_match.sv
module errcache_match #(
  parameter int unsigned WIDTH = errcache_pkg::DEF_WIDTH,
  parameter int unsigned DEPTH = errcache_pkg::DEF_DEPTH
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] lines_i,
  input  logic [DEPTH-1:0]            occ_i,
  input  logic [WIDTH-1:0]            word_i,
  output logic                        hit_o
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = occ_i[g] && (lines_i[g] == word_i);
  end

  assign hit_o = |hit_vec;

  // Distinct words are never stored twice, so at most one line can match.
  always_comb begin
    assert_single_hit_R3: assert ($onehot0(hit_vec) || $isunknown(hit_vec));
  end
endmodule

// File: rtl/errcache_store.sv
module errcache_store #(
  parameter int unsigned WIDTH = errcache_pkg::DEF_WIDTH,
  parameter int unsigned DEPTH = errcache_pkg::DEF_DEPTH,
  localparam int unsigned CW   = errcache_pkg::cnt_bits(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [WIDTH-1:0]            word_i,
  output logic [DEPTH-1:0][WIDTH-1:0] lines_o,
  output logic [DEPTH-1:0]            occ_o,
  output logic [CW-1:0]               cnt_o,
  output logic                        full_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (wr_en_i && !full_o)  cnt_q <= cnt_q + CW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_line
    logic [WIDTH-1:0] line_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               line_q <= '0;
      else if (wr_en_i && cnt_q == CW'(g))       line_q <= word_i;
    end
    assign lines_o[g] = line_q;
    assign occ_o[g]   = cnt_q > CW'(g);
  end

  assign cnt_o  = cnt_q;
  assign full_o = cnt_q == CW'(DEPTH);

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_no_write_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !wr_en_i);
endmodule

// File: rtl/errcache_host.sv
module errcache_host #(
  parameter int unsigned DEPTH = errcache_pkg::DEF_DEPTH,
  localparam int unsigned CW   = errcache_pkg::cnt_bits(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] wr_cnt_i,
  input  logic          ack_i,
  output logic [CW-1:0] rd_ptr_o,
  output logic [CW-1:0] pending_o,
  output logic          irq_o
);
  logic [CW-1:0] rd_q;
  logic          gap_q;
  logic          ack_ok;

  assign pending_o = wr_cnt_i - rd_q;
  assign ack_ok    = ack_i && (pending_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      gap_q <= 1'b0;
    end else begin
      if (ack_ok) rd_q <= rd_q + CW'(1);
      gap_q <= ack_ok;
    end
  end

  // Low for one cycle after each acknowledge: one rising edge per entry.
  assign irq_o    = (pending_o != '0) && !gap_q;
  assign rd_ptr_o = rd_q;

  assert_irq_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pending_o != '0) |=> !irq_o);
  assert_irq_needs_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pending_o != '0);
  assert_idle_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pending_o == '0) |=> $stable(rd_q));
  assert_rd_behind_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q <= wr_cnt_i);
endmodule

// File: rtl/errcache_top.sv
module errcache_top #(
  parameter int unsigned WIDTH = errcache_pkg::DEF_WIDTH,
  parameter int unsigned DEPTH = errcache_pkg::DEF_DEPTH,
  localparam int unsigned CW   = errcache_pkg::cnt_bits(DEPTH),
  localparam int unsigned IW   = errcache_pkg::idx_bits(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msg_valid_i,
  input  logic [WIDTH-1:0] msg_data_i,
  input  logic             ack_i,
  input  logic             ovf_clr_i,
  output logic             irq_o,
  output logic [WIDTH-1:0] entry_o,
  output logic [CW-1:0]    pending_o,
  output logic             ovf_o
);
  logic [DEPTH-1:0][WIDTH-1:0] lines;
  logic [DEPTH-1:0]            occ;
  logic [CW-1:0]               wr_cnt;
  logic [CW-1:0]               rd_ptr;
  logic                        full;
  logic                        hit;
  logic                        fresh;
  logic                        drop;
  logic                        ovf_q;

  errcache_match #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_match (
    .lines_i (lines),
    .occ_i   (occ),
    .word_i  (msg_data_i),
    .hit_o   (hit)
  );

  assign fresh = msg_valid_i && !hit;
  assign drop  = fresh && full;

  errcache_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (fresh && !full),
    .word_i  (msg_data_i),
    .lines_o (lines),
    .occ_o   (occ),
    .cnt_o   (wr_cnt),
    .full_o  (full)
  );

  errcache_host #(.DEPTH(DEPTH)) u_host (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_cnt_i  (wr_cnt),
    .ack_i     (ack_i),
    .rd_ptr_o  (rd_ptr),
    .pending_o (pending_o),
    .irq_o     (irq_o)
  );

  // Set has priority over clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (drop)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign ovf_o   = ovf_q;
  assign entry_o = (pending_o != '0) ? lines[rd_ptr[IW-1:0]] : '0;

  assert_dup_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && hit) |=> $stable(wr_cnt));
  assert_ovf_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(msg_valid_i && full));
  assert_ovf_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  assert_entry_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o == '0) |-> (entry_o == '0));
endmodule

// File: tb/tb_errcache_top.sv
module tb_errcache_top;
  localparam int unsigned W  = 64;
  localparam int unsigned D  = 8;
  localparam int unsigned CW = $clog2(D + 1);
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          msg_valid_i = 1'b0;
  logic [W-1:0]  msg_data_i = '0;
  logic          ack_i = 1'b0;
  logic          ovf_clr_i = 1'b0;
  logic          irq_o;
  logic [W-1:0]  entry_o;
  logic [CW-1:0] pending_o;
  logic          ovf_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic [W-1:0] m_lines [D];
  int   m_cnt, m_rd;
  logic m_ovf, m_gap;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  errcache_top #(.WIDTH(W), .DEPTH(D)) dut (
    .clk_i, .rst_ni, .msg_valid_i, .msg_data_i, .ack_i, .ovf_clr_i,
    .irq_o, .entry_o, .pending_o, .ovf_o
  );

  function automatic void m_reset();
    for (int i = 0; i < D; i++) m_lines[i] = '0;
    m_cnt = 0; m_rd = 0; m_ovf = 1'b0; m_gap = 1'b0;
  endfunction

  function automatic void m_clock(logic v, logic [W-1:0] d, logic a, logic c);
    logic hit = 1'b0;
    logic acc = a && (m_cnt - m_rd) != 0;
    logic drp = 1'b0;
    for (int i = 0; i < m_cnt; i++) if (m_lines[i] == d) hit = 1'b1;
    if (v && !hit) begin
      if (m_cnt < D) begin m_lines[m_cnt] = d; m_cnt++; end
      else drp = 1'b1;
    end
    if (drp) m_ovf = 1'b1;
    else if (c) m_ovf = 1'b0;
    if (acc) m_rd++;
    m_gap = acc;
  endfunction

  task automatic chk(input string tag, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int p = m_cnt - m_rd;
    chk(tag, "pending", W'(pending_o), W'(p));
    chk("R6", "irq", W'(irq_o), W'((p != 0) && !m_gap));
    chk("R7", "entry", entry_o, (p != 0) ? m_lines[m_rd] : '0);
    chk("R5", "ovf", W'(ovf_o), W'(m_ovf));
  endtask

  // Inputs driven at negedge, outputs checked at the following negedge.
  task automatic step(input logic v, input logic [W-1:0] d, input logic a,
                      input logic c, input string tag);
    msg_valid_i = v; msg_data_i = d; ack_i = a; ovf_clr_i = c;
    @(posedge clk_i);
    m_clock(v, d, a, c);
    @(negedge clk_i);
    msg_valid_i = 1'b0; ack_i = 1'b0; ovf_clr_i = 1'b0;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_reset();
    @(negedge clk_i);
    compare("R1");
    chk("R1", "irq_in_reset", W'(irq_o), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");
  endtask

  function automatic logic [W-1:0] word(int k);
    return {32'hE770_0000 | 32'(k), 32'(k * 7 + 3)};
  endfunction

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_reset();
    do_reset();

    // R2: two distinct words
    step(1, word(1), 0, 0, "R2");
    chk("R2", "pending_after_first", W'(pending_o), W'(1));
    step(1, word(2), 0, 0, "R2");
    // R3: repeat of a pending word
    step(1, word(1), 0, 0, "R3");
    chk("R3", "pending_dup", W'(pending_o), W'(2));
    chk("R7", "oldest_first", entry_o, word(1));
    // R8: acknowledge, R6 gap
    step(0, '0, 1, 0, "R8");
    chk("R6", "irq_gap", W'(irq_o), '0);
    chk("R7", "advanced", entry_o, word(2));
    step(0, '0, 0, 0, "R6");
    chk("R6", "irq_back", W'(irq_o), W'(1));
    // R3: repeat of an acknowledged word
    step(1, word(1), 0, 0, "R3");
    chk("R3", "serviced_dup", W'(pending_o), W'(1));
    // R9: write and ack together
    step(1, word(3), 1, 0, "R9");
    chk("R9", "pending_same", W'(pending_o), W'(1));
    chk("R9", "entry_next", entry_o, word(3));
    // fill to capacity
    for (int k = 4; k <= D; k++) step(1, word(k), 0, 0, "R2");
    chk("R2", "full_pending", W'(pending_o), W'(D - 2));
    // R4: overflow
    step(1, word(99), 0, 0, "R4");
    chk("R4", "ovf_set", W'(ovf_o), W'(1));
    chk("R4", "no_store", W'(pending_o), W'(D - 2));
    step(1, word(5), 0, 0, "R3");
    chk("R3", "dup_when_full_no_ovf_change", W'(ovf_o), W'(1));
    // R5: sticky, clear, set-over-clear
    step(0, '0, 0, 0, "R5");
    step(0, '0, 0, 1, "R5");
    chk("R5", "cleared", W'(ovf_o), '0);
    step(1, word(98), 0, 1, "R5");
    chk("R5", "set_wins", W'(ovf_o), W'(1));
    // drain, R4 dropped word never shown, R8 idle ack
    for (int k = 0; k < D; k++) begin
      if (pending_o != '0) begin
        chk("R4", "not_dropped", W'(entry_o == word(99) || entry_o == word(98)), '0);
        step(0, '0, 1, 0, "R8");
      end
    end
    step(0, '0, 1, 0, "R8");
    chk("R8", "idle_ack", W'(pending_o), '0);
    step(1, word(100), 0, 0, "R4");
    chk("R4", "still_full_after_drain", W'(ovf_o), W'(1));

    // random phase with a small pool so repeats are frequent
    for (int r = 0; r < 4; r++) begin
      do_reset();
      for (int i = 0; i < 120; i++) begin
        logic v = ($urandom % 3) != 0;
        logic a = ($urandom % 4) == 0;
        logic c = ($urandom % 10) == 0;
        step(v, word($urandom % 11), a, c, "R2");
      end
    end

    // R1: asynchronous reset asserted away from a clock edge
    step(1, word(7), 0, 0, "R2");
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    m_reset();
    #1;
    chk("R1", "async_pending", W'(pending_o), '0);
    chk("R1", "async_irq", W'(irq_o), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule